// File: doc/BRIEF.md
# Trigger Event Packet Builder

This block turns each accepted trigger into a fixed ten-word record of 32-bit words and streams the record to a downstream datagram transmitter. In the cycle of the accepted-trigger strobe it latches every field of the record at once. The fields are a packet sequence number, a tagged header, the free-running timestamp, three running event counts, a trigger bitmap, the masked NIM input bits, the masked eSATA input bits and a tagged footer. The block keeps the timestamp and the counters itself. The trigger decision, the coincidence logic and the multiplicity count come from outside as plain inputs.

The record leaves through a valid/ready stream with a last marker on the final word. The controller has three states. `ST_IDLE` waits for a strobe. `ST_BODY` sends words 0 to 8. `ST_FOOT` sends the footer. The transitions are: IDLE to BODY on a strobe; BODY to FOOT when word 8 is accepted; FOOT to IDLE when the footer is accepted. Only one record is held at a time. A strobe that arrives while a record is in flight is counted but not packaged, and it raises a one-cycle dropped flag.

Top module: `trig_pkt_builder`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `m_valid` and `drop_flag` are 0. Reset also clears the sequence number, the timestamp and all three counters to 0.
- R2: A record is ten words in the fixed order: 0 sequence, 1 header, 2 timestamp, 3 accepted count, 4 input count, 5 pulser count, 6 bitmap, 7 masked NIM, 8 masked eSATA, 9 footer. `m_last` is 1 on word 9 only, and `m_valid` drops after the footer is accepted.
- R3: The header is `{4'h8, accepted_count[27:0]}` and the footer is `{4'h9, accepted_count[27:0]}`, with the same count in both.
- R4: Words 3, 4 and 5 already include any accepted-trigger, input-trigger or pulser event present in the strobe cycle. Input and pulser events that arrive while no strobe is present are still counted.
- R5: Word 2 is the timestamp counter value in the strobe cycle. The counter is cleared by reset and rises by one every clock.
- R6: Word 6 is the bitmap. Bit 0 is the 16-channel ADC OR, bit 1 the 32-channel ADC OR, bit 2 the combined ADC OR, bit 3 the NIM/eSATA OR, and bits 4, 5 and 6 the top, bottom and both coincidences. Bit 7 is 0, bits 23:8 hold `coinc_flags`, and bits 31:24 hold `mult_count[7:0]`.
- R7: Word 7 is `nim_raw & nim_mask` and word 8 is `esata_raw & esata_mask`, each carrying 2 bits per ADC across 16 ADCs. Input changes after the strobe do not alter the record.
- R8: A word advances only in a cycle where `m_valid` and `m_ready` are both 1. While `m_ready` is 0, `m_data` and `m_last` hold.
- R9: A strobe while `m_valid` is 1 sets `drop_flag` for exactly the next cycle and leaves the record in flight unchanged. It still increments the accepted count, but it does not advance the sequence number.
- R10: Word 0 starts at 0 after reset and rises by one for each record whose footer is accepted.
- R11: A strobe while idle makes `m_valid` 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the timestamp clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_accept | input | 1 | Accepted-trigger strobe |
| trig_in_evt | input | 1 | Input-trigger event pulse |
| pulser_evt | input | 1 | Pulser event pulse |
| or_adc16 | input | 1 | 16-channel ADC grand OR |
| or_adc32 | input | 1 | 32-channel ADC grand OR |
| or_adc_any | input | 1 | Combined ADC OR |
| or_ext | input | 1 | NIM/eSATA OR |
| coinc_top | input | 1 | Top coincidence |
| coinc_bot | input | 1 | Bottom coincidence |
| coinc_both | input | 1 | Combined coincidence |
| coinc_flags | input | 16 | Registered coincidence flags |
| mult_count | input | MULT_W (8) | Multiplicity count |
| nim_raw | input | 32 | NIM input bits, 2 per ADC |
| nim_mask | input | 32 | NIM enable mask |
| esata_raw | input | 32 | eSATA input bits, 2 per ADC |
| esata_mask | input | 32 | eSATA enable mask |
| m_ready | input | 1 | Downstream ready |
| m_valid | output | 1 | Word valid |
| m_data | output | 32 | Record word |
| m_last | output | 1 | Footer marker |
| drop_flag | output | 1 | Strobe dropped while busy |

## Verification
The bench changes every capture input right after the strobe. A design that sampled them while streaming would then emit the new values in words 6 to 8. Events that land in the strobe cycle itself must appear in the counts, so a design that latched the counters one cycle early would report values one short. Stalls on `m_ready` test whether the design skips or repeats a word. A second strobe during a stall checks for a missing `drop_flag`, an overwritten record and a sequence number that advances on the dropped trigger. A reset in mid-record must leave the stream idle and restart the sequence and the counters at zero.

// File: rtl/trig_pkt_pkg.sv
package trig_pkt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BODY = 2'd1,
        ST_FOOT = 2'd2
    } pkt_state_e;

    localparam int PKT_WORDS = 10;
    localparam int WORD_W    = 32;
    localparam int TAG_W     = 4;
    localparam logic [TAG_W-1:0] TAG_HEAD = 4'h8;
    localparam logic [TAG_W-1:0] TAG_FOOT = 4'h9;

    localparam int W_SEQ   = 0;
    localparam int W_HEAD  = 1;
    localparam int W_TS    = 2;
    localparam int W_ACC   = 3;
    localparam int W_IN    = 4;
    localparam int W_PULS  = 5;
    localparam int W_BMAP  = 6;
    localparam int W_NIM   = 7;
    localparam int W_ESATA = 8;
    localparam int W_FOOT  = 9;
endpackage

// File: rtl/trig_pkt_counters.sv
module trig_pkt_counters #(
    parameter int CNT_W  = 32,
    parameter int N_EVT  = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_EVT-1:0]            evt,
    output logic [CNT_W-1:0]            ts_now,
    output logic [N_EVT-1:0][CNT_W-1:0] cnt_next
);
    always_ff @(posedge clk) begin
        if (rst) ts_now <= '0;
        else     ts_now <= ts_now + CNT_W'(1);
    end

    for (genvar g = 0; g < N_EVT; g++) begin : g_evt
        logic [CNT_W-1:0] cnt_q;
        assign cnt_next[g] = cnt_q + CNT_W'(evt[g]);
        always_ff @(posedge clk) begin
            if (rst) cnt_q <= '0;
            else     cnt_q <= cnt_next[g];
        end
    end
endmodule

// File: rtl/trig_pkt_inputs.sv
module trig_pkt_inputs #(
    parameter int NUM_ADC  = 16,
    parameter int PIN_BITS = 2,
    parameter int MULT_W   = 8,
    localparam int PIN_W   = NUM_ADC * PIN_BITS
) (
    input  logic [6:0]        or_bits,
    input  logic [15:0]       coinc_flags,
    input  logic [MULT_W-1:0] mult_count,
    input  logic [PIN_W-1:0]  nim_raw,
    input  logic [PIN_W-1:0]  nim_mask,
    input  logic [PIN_W-1:0]  esata_raw,
    input  logic [PIN_W-1:0]  esata_mask,
    output logic [31:0]       bitmap,
    output logic [PIN_W-1:0]  nim_sel,
    output logic [PIN_W-1:0]  esata_sel
);
    assign bitmap = {mult_count[7:0], coinc_flags, 1'b0, or_bits};

    for (genvar a = 0; a < NUM_ADC; a++) begin : g_adc
        assign nim_sel[a*PIN_BITS +: PIN_BITS] =
            nim_raw[a*PIN_BITS +: PIN_BITS] & nim_mask[a*PIN_BITS +: PIN_BITS];
        assign esata_sel[a*PIN_BITS +: PIN_BITS] =
            esata_raw[a*PIN_BITS +: PIN_BITS] & esata_mask[a*PIN_BITS +: PIN_BITS];
    end
endmodule

// File: rtl/trig_pkt_store.sv
module trig_pkt_store #(
    parameter int NWORDS = 10,
    parameter int WIDTH  = 32,
    localparam int SEL_W = $clog2(NWORDS)
) (
    input  logic                          clk,
    input  logic                          load,
    input  logic [NWORDS-1:0][WIDTH-1:0]  words_in,
    input  logic [SEL_W-1:0]              sel,
    output logic [WIDTH-1:0]              word_out
);
    logic [NWORDS-1:0][WIDTH-1:0] held;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (load) held[w] <= words_in[w];
        end
    end

    assign word_out = held[sel];
endmodule

// File: rtl/trig_pkt_builder.sv
module trig_pkt_builder
    import trig_pkt_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NUM_ADC  = 16,
    parameter int PIN_BITS = 2,
    parameter int MULT_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         trig_accept,
    input  logic                         trig_in_evt,
    input  logic                         pulser_evt,
    input  logic                         or_adc16,
    input  logic                         or_adc32,
    input  logic                         or_adc_any,
    input  logic                         or_ext,
    input  logic                         coinc_top,
    input  logic                         coinc_bot,
    input  logic                         coinc_both,
    input  logic [15:0]                  coinc_flags,
    input  logic [MULT_W-1:0]            mult_count,
    input  logic [NUM_ADC*PIN_BITS-1:0]  nim_raw,
    input  logic [NUM_ADC*PIN_BITS-1:0]  nim_mask,
    input  logic [NUM_ADC*PIN_BITS-1:0]  esata_raw,
    input  logic [NUM_ADC*PIN_BITS-1:0]  esata_mask,
    input  logic                         m_ready,
    output logic                         m_valid,
    output logic [31:0]                  m_data,
    output logic                         m_last,
    output logic                         drop_flag
);
    localparam int PIN_W = NUM_ADC * PIN_BITS;
    localparam int IDX_W = $clog2(PKT_WORDS);
    localparam logic [IDX_W-1:0] IDX_PRE_FOOT = IDX_W'(W_FOOT - 1);
    localparam int LOW_W = WORD_W - TAG_W;

    pkt_state_e             state, state_nxt;
    logic [IDX_W-1:0]       idx;
    logic [WORD_W-1:0]      seq_q;
    logic                   xfer, capture;

    logic [CNT_W-1:0]       ts_now;
    logic [2:0][CNT_W-1:0]  cnt_next;
    logic [31:0]            bitmap;
    logic [PIN_W-1:0]       nim_sel, esata_sel;
    logic [PKT_WORDS-1:0][WORD_W-1:0] snap;

    assign xfer    = m_valid && m_ready;
    assign capture = trig_accept && (state == ST_IDLE);

    trig_pkt_counters #(.CNT_W(CNT_W), .N_EVT(3)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .evt      ({pulser_evt, trig_in_evt, trig_accept}),
        .ts_now   (ts_now),
        .cnt_next (cnt_next)
    );

    trig_pkt_inputs #(.NUM_ADC(NUM_ADC), .PIN_BITS(PIN_BITS), .MULT_W(MULT_W)) u_in (
        .or_bits     ({coinc_both, coinc_bot, coinc_top, or_ext, or_adc_any, or_adc32, or_adc16}),
        .coinc_flags (coinc_flags),
        .mult_count  (mult_count),
        .nim_raw     (nim_raw),
        .nim_mask    (nim_mask),
        .esata_raw   (esata_raw),
        .esata_mask  (esata_mask),
        .bitmap      (bitmap),
        .nim_sel     (nim_sel),
        .esata_sel   (esata_sel)
    );

    always_comb begin
        snap          = '0;
        snap[W_SEQ]   = seq_q;
        snap[W_HEAD]  = {TAG_HEAD, cnt_next[0][LOW_W-1:0]};
        snap[W_TS]    = WORD_W'(ts_now);
        snap[W_ACC]   = WORD_W'(cnt_next[0]);
        snap[W_IN]    = WORD_W'(cnt_next[1]);
        snap[W_PULS]  = WORD_W'(cnt_next[2]);
        snap[W_BMAP]  = bitmap;
        snap[W_NIM]   = WORD_W'(nim_sel);
        snap[W_ESATA] = WORD_W'(esata_sel);
        snap[W_FOOT]  = {TAG_FOOT, cnt_next[0][LOW_W-1:0]};
    end

    trig_pkt_store #(.NWORDS(PKT_WORDS), .WIDTH(WORD_W)) u_store (
        .clk      (clk),
        .load     (capture),
        .words_in (snap),
        .sel      (idx),
        .word_out (m_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            idx       <= '0;
            seq_q     <= '0;
            drop_flag <= 1'b0;
        end else begin
            state     <= state_nxt;
            drop_flag <= trig_accept && (state != ST_IDLE);
            if (capture)
                idx <= '0;
            else if (xfer && state == ST_BODY)
                idx <= idx + IDX_W'(1);
            if (xfer && state == ST_FOOT)
                seq_q <= seq_q + WORD_W'(1);
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (trig_accept) state_nxt = ST_BODY;
            ST_BODY: if (xfer && idx == IDX_PRE_FOOT) state_nxt = ST_FOOT;
            ST_FOOT: if (xfer) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        m_valid = 1'b0;
        m_last  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_BODY: m_valid = 1'b1;
            ST_FOOT: begin
                m_valid = 1'b1;
                m_last  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/trig_pkt_builder_chk.sv
module trig_pkt_builder_chk (
    input logic        clk,
    input logic        rst,
    input logic        trig_accept,
    input logic        m_ready,
    input logic        m_valid,
    input logic [31:0] m_data,
    input logic        m_last,
    input logic        drop_flag
);
    logic [3:0]  word_no;
    logic [27:0] head_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_no  <= '0;
            head_low <= '0;
        end else if (m_valid && m_ready) begin
            word_no <= m_last ? 4'd0 : word_no + 4'd1;
            if (word_no == 4'd1) head_low <= m_data[27:0];
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!m_valid && !drop_flag));

    a_r2_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
        m_last |-> m_valid);

    a_r3_header_tag: assert property (@(posedge clk) disable iff (rst)
        (m_valid && word_no == 4'd1) |-> (m_data[31:28] == 4'h8));

    a_r3_footer_tag: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_last) |-> (m_data[31:28] == 4'h9 && m_data[27:0] == head_low));

    a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    a_r9_drop_busy: assert property (@(posedge clk) disable iff (rst)
        (m_valid && trig_accept) |=> drop_flag);

    a_r9_drop_cause: assert property (@(posedge clk) disable iff (rst)
        (!m_valid || !trig_accept) |=> !drop_flag);

    a_r11_start: assert property (@(posedge clk) disable iff (rst)
        (!m_valid && trig_accept) |=> m_valid);
endmodule

bind trig_pkt_builder trig_pkt_builder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .trig_accept (trig_accept),
    .m_ready     (m_ready),
    .m_valid     (m_valid),
    .m_data      (m_data),
    .m_last      (m_last),
    .drop_flag   (drop_flag)
);

// File: tb/trig_pkt_builder_test.sv
`timescale 1ns/1ps
module trig_pkt_builder_test;
    typedef struct packed {
        logic [6:0]  ors;
        logic [15:0] flags;
        logic [7:0]  mult;
        logic [31:0] nim;
        logic [31:0] nmask;
        logic [31:0] esa;
        logic [31:0] emask;
        logic        in_evt;
        logic        pul_evt;
        logic        stall;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{7'h01, 16'h0001, 8'h01, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'hAAAA_5555, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0},
        '{7'h7F, 16'hFFFF, 8'hFF, 32'h1234_5678, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 1'b1, 1'b0, 1'b1},
        '{7'h2A, 16'hA5C3, 8'h80, 32'h0000_0000, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0},
        '{7'h50, 16'h0F00, 8'h3C, 32'hCAFE_F00D, 32'h3333_CCCC, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b1, 1'b1},
        '{7'h00, 16'h0000, 8'h00, 32'h8000_0001, 32'h8000_0001, 32'h7FFF_FFFE, 32'h0000_0000, 1'b1, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst, trig_accept, trig_in_evt, pulser_evt, m_ready;
    logic or_adc16, or_adc32, or_adc_any, or_ext, coinc_top, coinc_bot, coinc_both;
    logic [15:0] coinc_flags;
    logic [7:0]  mult_count;
    logic [31:0] nim_raw, nim_mask, esata_raw, esata_mask;
    logic        m_valid, m_last, drop_flag;
    logic [31:0] m_data;

    int n_chk = 0, n_fail = 0;
    logic [31:0] ts_m, acc_m, in_m, pul_m, seq_m;
    logic [31:0] exp_w [10];

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) ts_m <= '0;
        else     ts_m <= ts_m + 32'd1;
    end

    trig_pkt_builder uut (
        .clk(clk), .rst(rst), .trig_accept(trig_accept), .trig_in_evt(trig_in_evt),
        .pulser_evt(pulser_evt), .or_adc16(or_adc16), .or_adc32(or_adc32),
        .or_adc_any(or_adc_any), .or_ext(or_ext), .coinc_top(coinc_top),
        .coinc_bot(coinc_bot), .coinc_both(coinc_both), .coinc_flags(coinc_flags),
        .mult_count(mult_count), .nim_raw(nim_raw), .nim_mask(nim_mask),
        .esata_raw(esata_raw), .esata_mask(esata_mask), .m_ready(m_ready),
        .m_valid(m_valid), .m_data(m_data), .m_last(m_last), .drop_flag(drop_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_caps(input vec_t v);
        {coinc_both, coinc_bot, coinc_top, or_ext, or_adc_any, or_adc32, or_adc16} = v.ors;
        coinc_flags = v.flags;
        mult_count  = v.mult;
        nim_raw = v.nim;   nim_mask = v.nmask;
        esata_raw = v.esa; esata_mask = v.emask;
    endtask

    // strobe at a negedge; returns at the next negedge, where the record is valid
    task automatic fire(input vec_t v);
        @(negedge clk);
        drive_caps(v);
        trig_accept = 1'b1;
        trig_in_evt = v.in_evt;
        pulser_evt  = v.pul_evt;
        acc_m = acc_m + 1;
        in_m  = in_m + 32'(v.in_evt);
        pul_m = pul_m + 32'(v.pul_evt);
        exp_w[0] = seq_m;
        exp_w[1] = {4'h8, acc_m[27:0]};
        exp_w[2] = ts_m;
        exp_w[3] = acc_m;
        exp_w[4] = in_m;
        exp_w[5] = pul_m;
        exp_w[6] = {v.mult, v.flags, 1'b0, v.ors};
        exp_w[7] = v.nim & v.nmask;
        exp_w[8] = v.esa & v.emask;
        exp_w[9] = {4'h9, acc_m[27:0]};
        @(negedge clk);
        trig_accept = 1'b0; trig_in_evt = 1'b0; pulser_evt = 1'b0;
        drive_caps(~v);   // R7: later input changes must not reach the record
        chk("R11 valid after strobe", 32'(m_valid), 32'd1);
    endtask

    task automatic collect(input logic stall);
        int idx = 0;
        int cyc = 0;
        while (idx < 10 && cyc < 200) begin
            m_ready = stall ? cyc[0] : 1'b1;
            chk("R8 valid held", 32'(m_valid), 32'd1);
            chk($sformatf("R2 word %0d data", idx), m_data, exp_w[idx]);
            chk("R2 last marker", 32'(m_last), 32'(idx == 9));
            if (m_ready) idx++;
            cyc++;
            @(negedge clk);
        end
        m_ready = 1'b0;
        seq_m = seq_m + 1;   // R10
        chk("R2 idle after footer", 32'(m_valid), 32'd0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 valid low in reset", 32'(m_valid), 32'd0);
        chk("R1 drop low in reset", 32'(drop_flag), 32'd0);
        rst = 1'b0;
        acc_m = 0; in_m = 0; pul_m = 0; seq_m = 0;
        @(negedge clk);
        chk("R1 valid low after reset", 32'(m_valid), 32'd0);
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        trig_accept = 0; trig_in_evt = 0; pulser_evt = 0; m_ready = 0;
        drive_caps('0);
        do_reset();

        // table walk: R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            fire(VECS[i]);
            collect(VECS[i].stall);
            repeat (i) @(negedge clk);
        end

        // R4: events outside a strobe are still counted
        trig_in_evt = 1'b1; pulser_evt = 1'b1;
        @(negedge clk);
        @(negedge clk);
        pulser_evt = 1'b0;
        @(negedge clk);
        trig_in_evt = 1'b0;
        in_m = in_m + 3; pul_m = pul_m + 2;
        fire(VECS[2]);
        collect(1'b0);

        // R9: strobe during a stalled record
        fire(VECS[1]);
        m_ready = 1'b0;
        @(negedge clk);
        trig_accept = 1'b1; trig_in_evt = 1'b1;
        acc_m = acc_m + 1; in_m = in_m + 1;
        @(negedge clk);
        trig_accept = 1'b0; trig_in_evt = 1'b0;
        chk("R9 drop flag raised", 32'(drop_flag), 32'd1);
        @(negedge clk);
        chk("R9 drop flag one cycle", 32'(drop_flag), 32'd0);
        collect(1'b1);
        fire(VECS[3]);   // R10: sequence advanced once, count includes dropped strobe
        collect(1'b0);

        // R1: reset in the middle of a record
        fire(VECS[0]);
        m_ready = 1'b1;
        repeat (3) @(negedge clk);
        m_ready = 1'b0;
        do_reset();
        fire(VECS[4]);
        chk("R10 sequence restarts", m_data, 32'd0);
        collect(1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule